// File: doc/BRIEF.md
# Word Stack Engine on a Byte Memory

This block carries out single-word push and pop operations for a 16-bit stack that sits in a byte-wide, single-ported memory. It owns the stack offset register. It forms every physical byte address from a segment base and that offset: the base is shifted left by four bit positions and the offset is added. A push request stores the word as two byte writes placed just below the current offset, and then lowers the offset by two. A pop request fetches two bytes starting at the current offset, joins them into a word, and then raises the offset by two.

The surrounding logic pulses a push or pop strobe for one cycle and then waits for the one-cycle `done` pulse. The memory is an external synchronous RAM whose read data appears one cycle after the address is presented. All memory-side outputs come straight from registers. The segment base is sampled in the cycle the request is accepted and is held for the rest of that operation.

Top module: `word_stack_engine`

## Requirements
- R1: A push sampled at clock edge n drives `mem_we`=1, `mem_addr` = phys(offset-1) and `mem_wdata` = push_data[15:8] during the cycle after edge n.
- R2: During the cycle after edge n+1, a push drives `mem_we`=1, `mem_addr` = phys(offset-2) and `mem_wdata` = push_data[7:0].
- R3: When a push finishes, `done` is high for exactly one cycle, the cycle after edge n+2, and `sp_out` in that same cycle is the old offset minus 2.
- R4: A pop sampled at edge n presents phys(offset) after edge n and phys(offset+1) after edge n+1, with `mem_we` low throughout. After edge n+3, `done` pulses for one cycle, `pop_data` = {byte at offset+1, byte at offset}, and `sp_out` = old offset + 2.
- R5: The physical address is (segment × 16 + offset) modulo 2^20. The segment used is the value of `seg_base` at the accepting edge, even if `seg_base` changes later in the operation.
- R6: All offset arithmetic wraps modulo 2^16. A push at offset 0000h writes to offsets FFFFh and FFFEh and leaves 0000h-2 = FFFEh. A pop at FFFEh reads FFFEh and FFFFh and leaves 0000h.
- R7: When `push_req` and `pop_req` are both high at an accepting edge, only the push is carried out.
- R8: Requests that arrive while an operation is in progress have no effect on memory, on `sp_out` or on later results.
- R9: Synchronous reset sets `sp_out` to 0000h and holds `done` and `mem_we` low.
- R10: `mem_we` is asserted only during a push, and for exactly two consecutive cycles per push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push strobe, sampled when idle |
| pop_req | input | 1 | Pop strobe, sampled when idle |
| push_data | input | 16 | Word to push |
| seg_base | input | 16 | Stack segment base |
| pop_data | output | 16 | Last popped word, valid from the `done` pulse |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Current stack offset |
| mem_addr | output | 20 | Byte memory address |
| mem_wdata | output | 8 | Byte memory write data |
| mem_rdata | input | 8 | Byte memory read data, one cycle after the address |
| mem_we | output | 1 | Byte memory write enable |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 16-bit offset, a 16-bit segment and a four-bit shift. With these values, a few operations starting from the reset offset carry the offset across its 0000h/FFFFh boundary in both directions. A segment of FFFFh pushes the physical sum past the top of the 20-bit space, so both wrap rules come into reach within a short run. The bench also sends requests into every busy cycle of a push, sends push and pop together, and changes the segment in the middle of a pop.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Sequencer states: each names the work that the next clock edge performs
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_END,
    ST_RD_HI,
    ST_RD_CAP,
    ST_RD_END
  } stk_state_e;

  // Offset variants that feed the address generator
  typedef enum logic [1:0] {
    OFS_CUR,
    OFS_M1,
    OFS_M2,
    OFS_P1
  } ofs_sel_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       push_req,
  input  logic       pop_req,
  output stk_state_e state_q,
  output logic       accept_push,
  output logic       accept_pop,
  output logic       we_next,
  output logic       addr_load,
  output logic       grab_lo,
  output logic       fin_push,
  output logic       fin_pop,
  output ofs_sel_e   ofs_sel
);

  stk_state_e state_d;

  always_comb begin
    accept_push = (state_q == ST_IDLE) && push_req;
    accept_pop  = (state_q == ST_IDLE) && !push_req && pop_req;
    state_d     = state_q;
    ofs_sel     = OFS_CUR;
    case (state_q)
      ST_IDLE: begin
        if (accept_push) begin
          state_d = ST_WR_LO;
          ofs_sel = OFS_M1;
        end else if (accept_pop) begin
          state_d = ST_RD_HI;
        end
      end
      ST_WR_LO: begin
        state_d = ST_WR_END;
        ofs_sel = OFS_M2;
      end
      ST_WR_END: state_d = ST_IDLE;
      ST_RD_HI: begin
        state_d = ST_RD_CAP;
        ofs_sel = OFS_P1;
      end
      ST_RD_CAP: state_d = ST_RD_END;
      ST_RD_END: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    we_next   = accept_push || (state_q == ST_WR_LO);
    addr_load = accept_push || accept_pop ||
                (state_q == ST_WR_LO) || (state_q == ST_RD_HI);
    grab_lo   = (state_q == ST_RD_CAP);
    fin_push  = (state_q == ST_WR_END);
    fin_pop   = (state_q == ST_RD_END);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int OFF_W    = 16,
  parameter int SP_RESET = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec2,
  input  logic             inc2,
  input  ofs_sel_e         sel,
  output logic [OFF_W-1:0] sp_q,
  output logic [OFF_W-1:0] ofs
);

  localparam logic [OFF_W-1:0] ONE   = OFF_W'(1);
  localparam logic [OFF_W-1:0] TWO   = OFF_W'(2);
  localparam logic [OFF_W-1:0] RST_V = OFF_W'(SP_RESET);

  // Offset register; plain binary arithmetic wraps inside the segment
  always_ff @(posedge clk) begin
    if (rst)       sp_q <= RST_V;
    else if (dec2) sp_q <= sp_q - TWO;
    else if (inc2) sp_q <= sp_q + TWO;
  end

  always_comb begin
    case (sel)
      OFS_M1:  ofs = sp_q - ONE;
      OFS_M2:  ofs = sp_q - TWO;
      OFS_P1:  ofs = sp_q + ONE;
      default: ofs = sp_q;
    endcase
  end

endmodule

// File: rtl/stk_agen.sv
module stk_agen #(
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int OFF_W     = 16,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] base;

  generate
    if (SEG_SHIFT == 0) begin : g_flat
      assign base = seg;
    end else begin : g_shift
      assign base = {seg, {SEG_SHIFT{1'b0}}};
    end
  endgenerate

  // The sum is truncated to the physical width, so it wraps at the top
  assign addr = base + ADDR_W'(off);

endmodule

// File: rtl/stk_pack.sv
module stk_pack #(
  parameter int BYTE_W  = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grab_lo,
  input  logic              finish,
  input  logic [BYTE_W-1:0] rbyte,
  output logic [WORD_W-1:0] word_q
);

  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      word_q <= '0;
    end else begin
      if (grab_lo) lo_q   <= rbyte;
      if (finish)  word_q <= {rbyte, lo_q};
    end
  end

endmodule

// File: rtl/word_stack_engine.sv
module word_stack_engine
  import stk_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int OFF_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SP_RESET  = 0,
  localparam int WORD_W   = 2 * BYTE_W,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [WORD_W-1:0] push_data,
  input  logic [SEG_W-1:0]  seg_base,
  output logic [WORD_W-1:0] pop_data,
  output logic              done,
  output logic [OFF_W-1:0]  sp_out,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we
);

  stk_state_e        state_q;
  ofs_sel_e          ofs_sel;
  logic              accept_push, accept_pop, we_next, addr_load;
  logic              grab_lo, fin_push, fin_pop;
  logic [OFF_W-1:0]  ofs;
  logic [SEG_W-1:0]  seg_q, seg_use;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] agen_addr;

  stk_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .state_q     (state_q),
    .accept_push (accept_push),
    .accept_pop  (accept_pop),
    .we_next     (we_next),
    .addr_load   (addr_load),
    .grab_lo     (grab_lo),
    .fin_push    (fin_push),
    .fin_pop     (fin_pop),
    .ofs_sel     (ofs_sel)
  );

  stk_ptr #(
    .OFF_W    (OFF_W),
    .SP_RESET (SP_RESET)
  ) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .dec2 (fin_push),
    .inc2 (fin_pop),
    .sel  (ofs_sel),
    .sp_q (sp_out),
    .ofs  (ofs)
  );

  // The segment is taken live on the accepting edge and from the latch afterwards
  assign seg_use = (state_q == ST_IDLE) ? seg_base : seg_q;

  stk_agen #(
    .SEG_W     (SEG_W),
    .SEG_SHIFT (SEG_SHIFT),
    .OFF_W     (OFF_W)
  ) u_agen (
    .seg  (seg_use),
    .off  (ofs),
    .addr (agen_addr)
  );

  stk_pack #(
    .BYTE_W (BYTE_W)
  ) u_pack (
    .clk     (clk),
    .rst     (rst),
    .grab_lo (grab_lo),
    .finish  (fin_pop),
    .rbyte   (mem_rdata),
    .word_q  (pop_data)
  );

  // Operand latches
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      word_q <= '0;
    end else begin
      if (accept_push || accept_pop) seg_q  <= seg_base;
      if (accept_push)               word_q <= push_data;
    end
  end

  // Registered memory port and completion pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      mem_we <= we_next;
      done   <= fin_push || fin_pop;
      if (addr_load) mem_addr <= agen_addr;
      if (we_next)
        mem_wdata <= accept_push ? push_data[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int OFF_W    = 16,
  parameter int SP_RESET = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             mem_we,
  input logic [OFF_W-1:0] sp_out
);

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp_out == OFF_W'(SP_RESET)) && !done && !mem_we);

  // R10
  we_pair_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> mem_we);

  // R10
  we_pair_end_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |=> !mem_we);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> (done && (sp_out == $past(sp_out) - OFF_W'(2))));

  // R4
  pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(mem_we)) |-> (sp_out == $past(sp_out) + OFF_W'(2)));

endmodule

bind word_stack_engine stk_chk #(
  .OFF_W    (OFF_W),
  .SP_RESET (SP_RESET)
) u_stk_chk (
  .clk    (clk),
  .rst    (rst),
  .done   (done),
  .mem_we (mem_we),
  .sp_out (sp_out)
);

// File: tb/tb_word_stack_engine.sv
`timescale 1ns/1ps
module tb_word_stack_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 1'b0, pop_req = 1'b0;
  logic [15:0] push_data = '0, seg_base = '0;
  logic [15:0] pop_data, sp_out;
  logic        done, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit armed = 1'b0;

  always #2.5 clk = ~clk;

  word_stack_engine dut (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .seg_base(seg_base), .pop_data(pop_data),
    .done(done), .sp_out(sp_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h3, a[19:16]};
  endfunction

  // Environment: synchronous byte RAM, unwritten bytes read as a pattern
  logic [7:0] env_mem [int];
  function automatic logic [7:0] env_rd(input logic [19:0] a);
    return env_mem.exists(int'(a)) ? env_mem[int'(a)] : pat(a);
  endfunction
  always @(posedge clk) begin
    if (mem_we) env_mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= env_rd(mem_addr);
  end

  // Reference model: word list kept as bytes, with a countdown per operation
  logic [7:0]  ref_mem [int];
  function automatic logic [7:0] ref_rd(input logic [19:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : pat(a);
  endfunction
  logic [15:0] m_sp = '0, m_seg = '0, m_word = '0, m_rd = '0;
  logic [19:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  int          m_cnt = 0;
  bit          m_push = 1'b0, m_done = 1'b0, m_we = 1'b0, m_aval = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_sp = '0; m_cnt = 0; m_done = 0; m_we = 0; m_aval = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_push) begin
          if (m_cnt == 1) begin
            m_we = 1; m_aval = 1; m_addr = phys(m_seg, m_sp - 16'd2); m_wd = m_word[7:0];
          end else begin
            m_we = 0; m_aval = 0;
            ref_mem[int'(phys(m_seg, m_sp - 16'd1))] = m_word[15:8];
            ref_mem[int'(phys(m_seg, m_sp - 16'd2))] = m_word[7:0];
            m_sp = m_sp - 16'd2; m_done = 1;
          end
        end else begin
          if (m_cnt == 2) m_addr = phys(m_seg, m_sp + 16'd1);
          else if (m_cnt == 1) m_aval = 0;
          else begin
            m_rd = {ref_rd(phys(m_seg, m_sp + 16'd1)), ref_rd(phys(m_seg, m_sp))};
            m_sp = m_sp + 16'd2; m_done = 1;
          end
        end
      end else if (push_req) begin
        m_push = 1; m_cnt = 2; m_seg = seg_base; m_word = push_data;
        m_we = 1; m_aval = 1; m_addr = phys(seg_base, m_sp - 16'd1); m_wd = push_data[15:8];
      end else if (pop_req) begin
        m_push = 0; m_cnt = 3; m_seg = seg_base;
        m_we = 0; m_aval = 1; m_addr = phys(seg_base, m_sp);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && !rst) begin
      chk(done === m_done, "R3", "done", 32'(done), 32'(m_done));
      chk(sp_out === m_sp, "R6", "sp_out", 32'(sp_out), 32'(m_sp));
      chk(mem_we === m_we, "R10", "mem_we", 32'(mem_we), 32'(m_we));
      if (m_aval)
        chk(mem_addr === m_addr, m_push ? "R1" : "R4", "mem_addr", 32'(mem_addr), 32'(m_addr));
      if (m_we)
        chk(mem_wdata === m_wd, "R2", "mem_wdata", 32'(mem_wdata), 32'(m_wd));
      if (m_done && !m_push)
        chk(pop_data === m_rd, "R4", "pop_data", 32'(pop_data), 32'(m_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic push_op(input logic [15:0] d);
    @(negedge clk); push_req = 1; push_data = d;
    @(negedge clk); push_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_op();
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] envb(input logic [19:0] a);
    return env_rd(a);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    armed = 1;
    // R9 reset state
    chk(sp_out === 16'h0000, "R9", "sp after reset", 32'(sp_out), 32'h0);
    chk(done === 1'b0 && mem_we === 1'b0, "R9", "done/we after reset", 32'({done, mem_we}), 32'h0);

    // R1 R2 R6: first push from offset 0000h
    seg_base = 16'h1000;
    push_op(16'hA1B2);
    chk(envb(20'h1FFFF) === 8'hA1, "R1", "high byte at FFFF", 32'(envb(20'h1FFFF)), 32'hA1);
    chk(envb(20'h1FFFE) === 8'hB2, "R2", "low byte at FFFE", 32'(envb(20'h1FFFE)), 32'hB2);
    chk(sp_out === 16'hFFFE, "R3", "sp after push", 32'(sp_out), 32'hFFFE);
    push_op(16'h1234);
    chk(sp_out === 16'hFFFC, "R3", "sp after 2nd push", 32'(sp_out), 32'hFFFC);

    // R4 last in first out
    pop_op();
    chk(pop_data === 16'h1234, "R4", "pop newest", 32'(pop_data), 32'h1234);
    pop_op();
    chk(pop_data === 16'hA1B2, "R4", "pop older", 32'(pop_data), 32'hA1B2);
    chk(sp_out === 16'h0000, "R6", "sp wraps to 0", 32'(sp_out), 32'h0);

    // R4 pop of bytes never written
    pop_op();
    chk(pop_data === {pat(20'h10001), pat(20'h10000)}, "R4", "pop fresh bytes",
        32'(pop_data), 32'({pat(20'h10001), pat(20'h10000)}));
    push_op(16'hC3D4);
    chk(envb(20'h10001) === 8'hC3, "R1", "push at offset 2", 32'(envb(20'h10001)), 32'hC3);

    // R7 simultaneous requests
    @(negedge clk); push_req = 1; pop_req = 1; push_data = 16'h5566;
    @(negedge clk); push_req = 0; pop_req = 0;
    repeat (3) @(negedge clk);
    chk(sp_out === 16'hFFFE, "R7", "push wins", 32'(sp_out), 32'hFFFE);
    chk(envb(20'h1FFFF) === 8'h55, "R7", "pushed byte", 32'(envb(20'h1FFFF)), 32'h55);

    // R8 requests during a push are ignored
    @(negedge clk); push_req = 1; push_data = 16'h7788;
    @(negedge clk); push_req = 1; pop_req = 1; push_data = 16'h9999;
    @(negedge clk); push_req = 0; pop_req = 1;
    @(negedge clk); pop_req = 0;
    repeat (2) @(negedge clk);
    chk(sp_out === 16'hFFFC, "R8", "busy requests ignored", 32'(sp_out), 32'hFFFC);
    chk(envb(20'h1FFFD) === 8'h77, "R8", "stored byte", 32'(envb(20'h1FFFD)), 32'h77);
    pop_op();
    chk(pop_data === 16'h7788, "R8", "word not replaced", 32'(pop_data), 32'h7788);
    pop_op();
    chk(pop_data === 16'h5566, "R6", "pop across FFFE", 32'(pop_data), 32'h5566);
    chk(sp_out === 16'h0000, "R6", "sp back to 0", 32'(sp_out), 32'h0);

    // R5 physical address wraps past 2^20
    seg_base = 16'hFFFF;
    push_op(16'hABCD);
    chk(envb(20'h0FFEF) === 8'hAB, "R5", "wrapped high addr", 32'(envb(20'h0FFEF)), 32'hAB);
    chk(envb(20'h0FFEE) === 8'hCD, "R5", "wrapped low addr", 32'(envb(20'h0FFEE)), 32'hCD);

    // R5 segment held for the whole pop
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0; seg_base = 16'h0000;
    repeat (4) @(negedge clk);
    chk(pop_data === 16'hABCD, "R5", "segment latched", 32'(pop_data), 32'hABCD);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule